// File: doc/BRIEF.md
# Sector ECC Syndrome Corrector

This block checks one 512-byte flash sector that is protected by a 24-bit Hamming code, which corrects single errors and detects double errors. After a sector has been read, the controller presents two 3-byte codes: the one fetched from the spare area and the one computed over the data as it streamed in. On a start pulse the block complements the stored code, splits both codes into two 12-bit halves and forms an odd and an even syndrome by XOR. It then sorts the outcome into four cases: clean, a single data-bit error, an error confined to the code bytes, or uncorrectable.

For a data-bit error the odd syndrome gives the failing byte and bit directly. When in-place fixing is enabled, the block repairs the sector buffer through a byte-wide port. It reads the addressed byte in one cycle and writes it back with the bit flipped in the next. Two saturating counters record corrected sectors and failed sectors. A synchronous clear input resets them.

Top module: `secc_corrector`

## Requirements
- R1: After reset, done, busy, buf_rd and buf_wr are 0, status is 00 and both counters are 0.
- R2: The stored code is complemented before use. For each code, half A is bits 11:0 (byte 0 plus the low nibble of byte 1) and half B is bits 23:12 (the high nibble of byte 1 plus byte 2). The odd syndrome is half A of the true stored code XOR half A of the calculated code; the even syndrome is the same over half B. When both syndromes are zero, status is 00.
- R3: When the odd syndrome equals the 12-bit complement of the even syndrome, status is 01. err_byte is odd[11:3] and err_bit is odd[2:0].
- R4: Otherwise, when the OR of the two syndromes has exactly one bit set, status is 10 and the buffer port is not used.
- R5: Every other nonzero syndrome pair gives status 11, and the buffer port is not used.
- R6: err_byte and err_bit are 0 whenever status is not 01.
- R7: With fix_en high and status 01, buf_rd is driven for one cycle at err_byte. In the next cycle buf_wr is driven at the same address with the read byte and bit err_bit inverted. done rises 3 cycles after the edge that samples start.
- R8: In all other cases the buffer port stays idle and done rises 1 cycle after the sampling edge. done is a one-cycle pulse. status holds until the next accepted start.
- R9: A start that arrives while busy is high is ignored. It changes neither the status nor the done pulses.
- R10: With done, cnt_fixed increments for status 01 or 10 and cnt_failed increments for status 11. Both counters saturate at 2^CNT_W-1.
- R11: cnt_clr zeroes both counters on the next edge, and it takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a check of the presented codes |
| fix_en | input | 1 | Allow in-place repair of the buffer |
| stored_code | input | 24 | Code read from the spare area, bit-inverted, byte 0 in bits 7:0 |
| calc_code | input | 24 | Code computed over the data as read |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Buffer repair in progress |
| status | output | 2 | 00 clean, 01 data fixed, 10 code-only error, 11 uncorrectable |
| err_byte | output | 9 | Failing byte offset (status 01 only) |
| err_bit | output | 3 | Failing bit offset (status 01 only) |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_rd | output | 1 | Buffer read strobe; data is due on the next cycle |
| buf_wr | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Repaired byte |
| buf_rdata | input | 8 | Byte returned by the buffer one cycle after buf_rd |
| cnt_fixed | output | CNT_W | Sectors reported as status 01 or 10 |
| cnt_failed | output | CNT_W | Sectors reported as status 11 |

## Verification
status, err_byte and err_bit are registered on the edge that samples start. done and the counters settle on that edge for a direct classification, and two edges later when a repair runs. The bench therefore drives inputs on falling edges and counts falling edges until done appears. It requires a count of 1 for a direct result and 3 for a repair, and it reads the buffer model and the counters only after done. The sweeps cover all 4096 data-error positions, all 24 single code-bit errors and all 276 two-bit syndromes, each compared with an outcome the bench computes arithmetically.

// File: rtl/secc_pkg.sv
package secc_pkg;
  localparam int CODE_W = 24;
  localparam int HALF_W = CODE_W / 2;
  localparam int BIT_W  = 3;
  localparam int BYTE_W = HALF_W - BIT_W;
  localparam int DATA_W = 1 << BIT_W;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_DATA  = 2'b01,
    ST_CODE  = 2'b10,
    ST_FAIL  = 2'b11
  } secc_status_e;

  // half A: byte 0 with the low nibble of byte 1 on top
  function automatic logic [HALF_W-1:0] half_a(input logic [CODE_W-1:0] c);
    return c[HALF_W-1:0];
  endfunction

  // half B: high nibble of byte 1 with byte 2 on top
  function automatic logic [HALF_W-1:0] half_b(input logic [CODE_W-1:0] c);
    return c[CODE_W-1:HALF_W];
  endfunction

  function automatic secc_status_e classify(input logic [HALF_W-1:0] odd,
                                            input logic [HALF_W-1:0] even);
    if (odd == '0 && even == '0)          return ST_CLEAN;
    else if (odd == ~even)                return ST_DATA;
    else if ($countones(odd | even) == 1) return ST_CODE;
    else                                  return ST_FAIL;
  endfunction
endpackage

// File: rtl/secc_syndrome.sv
module secc_syndrome
  import secc_pkg::*;
(
  input  logic [CODE_W-1:0] stored_code,
  input  logic [CODE_W-1:0] calc_code,
  output secc_status_e      cls,
  output logic [BYTE_W-1:0] fix_byte,
  output logic [BIT_W-1:0]  fix_bit
);
  logic [CODE_W-1:0] true_code;
  logic [HALF_W-1:0] syn_odd;
  logic [HALF_W-1:0] syn_even;

  always_comb begin
    true_code = ~stored_code;
    syn_odd   = half_a(true_code) ^ half_a(calc_code);
    syn_even  = half_b(true_code) ^ half_b(calc_code);
    cls       = classify(syn_odd, syn_even);
    fix_byte  = syn_odd[HALF_W-1:BIT_W];
    fix_bit   = syn_odd[BIT_W-1:0];
  end
endmodule

// File: rtl/secc_fix_seq.sv
module secc_fix_seq #(
  parameter int ADDR_W = 9,
  parameter int BIT_W  = 3,
  localparam int DATA_W = 1 << BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BIT_W-1:0]  bit_in,
  output logic              busy,
  output logic              finish,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              buf_rd,
  output logic              buf_wr,
  output logic [DATA_W-1:0] buf_wdata,
  input  logic [DATA_W-1:0] buf_rdata
);
  typedef enum logic [1:0] {SQ_IDLE, SQ_RD, SQ_WR} sq_e;
  sq_e               state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      addr_q <= '0;
      mask_q <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (launch) begin
          state  <= SQ_RD;
          addr_q <= addr_in;
          mask_q <= DATA_W'(1) << bit_in;
        end
        SQ_RD:   state <= SQ_WR;
        SQ_WR:   state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state != SQ_IDLE);
    buf_rd    = (state == SQ_RD);
    buf_wr    = (state == SQ_WR);
    finish    = buf_wr;
    buf_addr  = addr_q;
    buf_wdata = buf_wr ? (buf_rdata ^ mask_q) : '0;
  end

  p_rd_then_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd |=> buf_wr);
  p_wr_after_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |-> $past(buf_rd));
  p_wr_addr_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |-> $stable(buf_addr));
  p_single_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |-> $countones(buf_wdata ^ buf_rdata) == 1);
endmodule

// File: rtl/secc_sat_counter.sv
module secc_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (clr)                count <= '0;
    else if (inc && count != TOP) count <= count + W'(1);
  end

  p_clr_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
  p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP && !clr) |=> count == TOP);
  p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count == $past(count) || count == $past(count) + W'(1)));
endmodule

// File: rtl/secc_corrector.sv
module secc_corrector
  import secc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fix_en,
  input  logic [CODE_W-1:0] stored_code,
  input  logic [CODE_W-1:0] calc_code,
  input  logic              cnt_clr,
  output logic              done,
  output logic              busy,
  output logic [1:0]        status,
  output logic [BYTE_W-1:0] err_byte,
  output logic [BIT_W-1:0]  err_bit,
  output logic [BYTE_W-1:0] buf_addr,
  output logic              buf_rd,
  output logic              buf_wr,
  output logic [DATA_W-1:0] buf_wdata,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic [CNT_W-1:0]  cnt_fixed,
  output logic [CNT_W-1:0]  cnt_failed
);
  localparam int N_CNT = 2;

  secc_status_e      cls;
  logic [BYTE_W-1:0] fix_byte;
  logic [BIT_W-1:0]  fix_bit;
  secc_status_e      status_q;
  logic              accept, launch, direct_done, seq_finish, evt;
  secc_status_e      evt_cls;
  logic [N_CNT-1:0]  cnt_inc;
  logic [CNT_W-1:0]  cnt_arr [N_CNT];

  secc_syndrome u_syn (
    .stored_code (stored_code),
    .calc_code   (calc_code),
    .cls         (cls),
    .fix_byte    (fix_byte),
    .fix_bit     (fix_bit)
  );

  always_comb begin
    accept      = start && !busy;
    launch      = accept && (cls == ST_DATA) && fix_en;
    direct_done = accept && !launch;
    evt         = direct_done || seq_finish;
    evt_cls     = direct_done ? cls : status_q;
    cnt_inc[0]  = evt && (evt_cls == ST_DATA || evt_cls == ST_CODE);
    cnt_inc[1]  = evt && (evt_cls == ST_FAIL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= ST_CLEAN;
      err_byte <= '0;
      err_bit  <= '0;
      done     <= 1'b0;
    end else begin
      done <= evt;
      if (accept) begin
        status_q <= cls;
        err_byte <= (cls == ST_DATA) ? fix_byte : '0;
        err_bit  <= (cls == ST_DATA) ? fix_bit  : '0;
      end
    end
  end

  assign status = status_q;

  secc_fix_seq #(.ADDR_W(BYTE_W), .BIT_W(BIT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .addr_in   (fix_byte),
    .bit_in    (fix_bit),
    .busy      (busy),
    .finish    (seq_finish),
    .buf_addr  (buf_addr),
    .buf_rd    (buf_rd),
    .buf_wr    (buf_wr),
    .buf_wdata (buf_wdata),
    .buf_rdata (buf_rdata)
  );

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    secc_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc[g]),
      .count (cnt_arr[g])
    );
  end

  assign cnt_fixed  = cnt_arr[0];
  assign cnt_failed = cnt_arr[1];

  p_buf_only_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd || buf_wr) |-> status == ST_DATA);
  p_pos_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status != ST_DATA) |-> (err_byte == '0 && err_bit == '0));
  p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(status));
  p_no_done_while_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd |-> !done);
endmodule

// File: tb/secc_corrector_tb.sv
module secc_corrector_tb;
  localparam int CNT_W = 8;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, fix_en = 1'b0, cnt_clr = 1'b0;
  logic [23:0] stored_code = '0, calc_code = '0;
  logic        done, busy, buf_rd, buf_wr;
  logic [1:0]  status;
  logic [8:0]  err_byte, buf_addr;
  logic [2:0]  err_bit;
  logic [7:0]  buf_wdata, buf_rdata;
  logic [CNT_W-1:0] cnt_fixed, cnt_failed;

  int vectors = 0, miscompares = 0;
  int wr_cnt = 0, rd_cnt = 0, done_cnt = 0;
  int exp_fixed = 0, exp_failed = 0;
  logic [7:0] mem [512];
  logic [7:0] exp_mem [512];

  always #2 clk = ~clk;

  secc_corrector #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fix_en(fix_en),
    .stored_code(stored_code), .calc_code(calc_code), .cnt_clr(cnt_clr),
    .done(done), .busy(busy), .status(status), .err_byte(err_byte),
    .err_bit(err_bit), .buf_addr(buf_addr), .buf_rd(buf_rd), .buf_wr(buf_wr),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .cnt_fixed(cnt_fixed), .cnt_failed(cnt_failed)
  );

  always @(posedge clk) begin
    if (buf_rd) begin buf_rdata <= mem[buf_addr]; rd_cnt <= rd_cnt + 1; end
    if (buf_wr) begin mem[buf_addr] <= buf_wdata; wr_cnt <= wr_cnt + 1; end
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // the code pair whose syndromes are (odd, even): stored = ~(calc ^ pack)
  function automatic logic [23:0] pack_syn(input logic [11:0] odd, input logic [11:0] even);
    logic [7:0] b0, b1, b2;
    b0 = odd[7:0];
    b1 = {even[3:0], odd[11:8]};
    b2 = even[11:4];
    return {b2, b1, b0};
  endfunction

  function automatic logic [1:0] ref_cls(input logic [11:0] odd, input logic [11:0] even);
    if ({odd, even} == 24'h0) return 2'b00;
    if ((odd ^ even) == 12'hFFF) return 2'b01;
    if ($countones(odd | even) == 1) return 2'b10;
    return 2'b11;
  endfunction

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic run_sector(input logic [23:0] st, input logic [23:0] ca,
                            input logic fe, output int lat);
    @(negedge clk);
    stored_code = st; calc_code = ca; fix_en = fe; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    if (!done) chk(1'b0, "R8", "watchdog: done never rose", lat, 3);
  endtask

  // apply a syndrome pair, check status, position, latency and buffer traffic
  task automatic apply(input logic [11:0] odd, input logic [11:0] even,
                       input logic [23:0] ca, input logic fe, input string req);
    int lat, w0, r0;
    logic [1:0] ec;
    logic repair;
    ec = ref_cls(odd, even);
    repair = (ec == 2'b01) && fe;
    w0 = wr_cnt; r0 = rd_cnt;
    run_sector(~(ca ^ pack_syn(odd, even)), ca, fe, lat);
    chk(status == ec, req, "status", status, ec);
    if (ec == 2'b01) begin
      chk(err_byte == odd[11:3], "R3", "err_byte", err_byte, odd[11:3]);
      chk(err_bit == odd[2:0], "R3", "err_bit", err_bit, odd[2:0]);
    end else begin
      chk(err_byte == 0 && err_bit == 0, "R6", "position not zero", {err_byte, err_bit}, 0);
    end
    if (repair) begin
      exp_mem[odd[11:3]] = exp_mem[odd[11:3]] ^ (8'h1 << odd[2:0]);
      chk(lat == 3, "R7", "repair latency", lat, 3);
      chk(wr_cnt == w0 + 1 && rd_cnt == r0 + 1, "R7", "one read one write", wr_cnt - w0, 1);
      chk(mem[odd[11:3]] == exp_mem[odd[11:3]], "R7", "repaired byte",
          mem[odd[11:3]], exp_mem[odd[11:3]]);
    end else begin
      chk(lat == 1, "R8", "direct latency", lat, 1);
      chk(wr_cnt == w0 && rd_cnt == r0, "R8", "buffer touched", wr_cnt - w0, 0);
    end
    if (ec == 2'b01 || ec == 2'b10) exp_fixed = sat(exp_fixed + 1);
    if (ec == 2'b11) exp_failed = sat(exp_failed + 1);
    @(negedge clk);
    chk(!done, "R8", "done longer than one cycle", done, 0);
  endtask

  task automatic check_counters(input string req);
    chk(cnt_fixed == CNT_W'(exp_fixed), req, "cnt_fixed", cnt_fixed, exp_fixed);
    chk(cnt_failed == CNT_W'(exp_failed), req, "cnt_failed", cnt_failed, exp_failed);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not end", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(done == 0 && busy == 0, "R1", "done/busy in reset", {done, busy}, 0);
    chk(buf_rd == 0 && buf_wr == 0, "R1", "buffer strobes in reset", {buf_rd, buf_wr}, 0);
    chk(status == 2'b00, "R1", "status in reset", status, 0);
    chk(cnt_fixed == 0 && cnt_failed == 0, "R1", "counters in reset", {cnt_fixed, cnt_failed}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: clean sectors under varied code values
    for (int k = 0; k < 16; k++) apply(12'h0, 12'h0, 24'(k * 24'h13579B + 5), 1'b1, "R2");

    // R3/R7: every data-bit position, repaired in place
    for (int p = 0; p < 4096; p++)
      apply(12'(p), ~12'(p), 24'(p * 40503 + 17), 1'b1, "R3");
    check_counters("R10");

    // R3/R8: data errors reported without repair
    for (int p = 0; p < 4096; p += 67)
      apply(12'(p), ~12'(p), 24'(p * 911), 1'b0, "R3");

    // R11: clear
    @(negedge clk); cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
    exp_fixed = 0; exp_failed = 0;
    check_counters("R11");

    // R4: every single code-bit error
    for (int b = 0; b < 24; b++) begin
      logic [23:0] s;
      s = 24'h1 << b;
      apply(s[11:0], s[23:12], 24'(b * 12345), 1'b1, "R4");
    end
    check_counters("R10");

    // R5: every two-bit syndrome
    for (int i = 0; i < 24; i++)
      for (int j = i + 1; j < 24; j++) begin
        logic [23:0] s;
        s = (24'h1 << i) | (24'h1 << j);
        apply(s[11:0], s[23:12], 24'(i * 777 + j), 1'b1, "R5");
      end
    apply(12'hFFF, 12'hFFF, 24'h0F0F0F, 1'b1, "R5");
    apply(12'h0A5, 12'h3C3, 24'h123456, 1'b1, "R5");
    check_counters("R10");

    // R11: clear in the same cycle as an increment wins
    @(negedge clk); cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
    apply(12'h001, 12'h000, 24'h0, 1'b0, "R4");
    chk(cnt_fixed == 1, "R11", "count after clear", cnt_fixed, 1);
    @(negedge clk);
    stored_code = ~(24'h55 ^ pack_syn(12'h0, 12'h800)); calc_code = 24'h55;
    fix_en = 1'b0; start = 1'b1; cnt_clr = 1'b1;
    @(negedge clk); start = 1'b0; cnt_clr = 1'b0;
    chk(done == 1, "R8", "done for clear test", done, 1);
    chk(cnt_fixed == 0, "R11", "clear beats increment", cnt_fixed, 0);
    exp_fixed = 0; exp_failed = 0;

    // R9: start while busy is ignored
    begin
      int d0;
      logic [23:0] ca;
      ca = 24'hA1B2C3;
      @(negedge clk);
      d0 = done_cnt;
      stored_code = ~(ca ^ pack_syn(12'h2AD, ~12'h2AD)); calc_code = ca;
      fix_en = 1'b1; start = 1'b1;
      @(negedge clk);
      chk(busy == 1, "R9", "busy during repair", busy, 1);
      stored_code = ~(ca ^ pack_syn(12'h003, 12'h000));
      @(negedge clk); start = 1'b0;
      repeat (4) @(negedge clk);
      exp_mem[12'h2AD >> 3] = exp_mem[12'h2AD >> 3] ^ (8'h1 << 3'h5);
      chk(done_cnt == d0 + 1, "R9", "done pulses", done_cnt - d0, 1);
      chk(status == 2'b01, "R9", "status kept", status, 1);
      chk(err_byte == 9'h055 && err_bit == 3'h5, "R9", "position kept", {err_byte, err_bit}, {9'h055, 3'h5});
      chk(mem[9'h055] == exp_mem[9'h055], "R9", "repair intact", mem[9'h055], exp_mem[9'h055]);
      chk(cnt_fixed == 1 && cnt_failed == 0, "R10", "one count only", {cnt_fixed, cnt_failed}, {8'd1, 8'd0});
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule